// File: doc/BRIEF.md
# Prioritized Interrupt Controller with NMI

This block merges a set of external interrupt lines, a set of on-chip module interrupt lines and one non-maskable interrupt pin into a single request toward a CPU. Every maskable source owns a 4-bit priority register. The external sources and the module sources sit in separate register groups. A source is offered to the CPU only when its priority beats the CPU's current mask level. While the CPU runs in user mode, the priority must also beat a software-set user mask. Among the eligible sources, the highest priority wins. On a tie, the lowest source number wins.

The NMI pin is synchronized and rising-edge detected into a pending flag, which the CPU clears with an acknowledge pulse. A pending NMI ranks as level 16 and overrides every maskable source. A control bit can hold it back while the CPU block bit is set. Each accepted request carries its level, a source code and the mask value the CPU should load.

Top module: `prio_intc`

## Requirements
- R1: Addresses 0–3 hold the external source priorities and addresses 4–7 hold the module source priorities. Each uses bits [3:0], reads back as written, and a value of 0 disables the source.
- R2: A maskable source is forwarded only when its priority is strictly greater than `cpu_imask`.
- R3: Source codes are: external line i gives code i, module line j gives code 4+j, and NMI gives code 8. The highest eligible priority wins, and on equal priority the lowest code wins.
- R4: An accepted NMI reports level 16 and wins over every maskable source, whatever the value of `cpu_imask`.
- R5: A rising edge on `nmi_pin` sets a pending flag that stays set until an `nmi_ack` pulse. A pin held high does not set it again.
- R6: When bit 0 of address 8 is 1 and `cpu_bl` is 1, a pending NMI is not requested but stays pending. When bit 0 is 0, NMI is requested regardless of `cpu_bl`.
- R7: With a request, `new_imask_o` equals the accepted level, with 15 for NMI. Without a request, `irq_o`, level, code and `new_imask_o` are all 0.
- R8: Address 9, bits [3:0], is a user mask. While `cpu_user` is 1, a maskable source must also have a priority strictly greater than this mask. While `cpu_user` is 0, the user mask has no effect.
- R9: Bit 1 of address 8 is read-only and shows the synchronized level of `nmi_pin`.
- R10: A change on a request line reaches the outputs at the third clock edge. An NMI edge reaches them at the fourth. A change of `cpu_imask`, `cpu_bl`, `cpu_user` or a register reaches them at the next edge.
- R11: After reset, all registers read 0, no NMI is pending and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | 4 | External interrupt request lines |
| mod_req | input | 4 | On-chip module request lines |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| nmi_ack | input | 1 | Clears the pending NMI |
| cpu_imask | input | 4 | Current CPU interrupt mask level |
| cpu_bl | input | 1 | CPU block bit |
| cpu_user | input | 1 | CPU is in user mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_level_o | output | 5 | Accepted level (16 = NMI) |
| irq_src_o | output | 4 | Accepted source code |
| new_imask_o | output | 4 | Mask value for the CPU to load |

## Verification
Request lines pass through two synchronizer flops and one output register, so their effect is due at the third edge. The NMI pin goes through one more stage for edge detection, so its effect is due at the fourth edge. Mask inputs, the block bit, user mode and register writes go straight into the arbitration and appear at the next edge, while register reads are combinational. The bench drives inputs on the falling edge and samples just before a later falling edge. The sweeps wait long enough for the slowest path, and dedicated latency checks sample one edge before and exactly at each due edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIO_W = 4;
  localparam int LVL_W  = PRIO_W + 1;
  localparam logic [LVL_W-1:0] NMI_LEVEL = LVL_W'(1 << PRIO_W);

  // priority must beat the CPU mask and, in user mode, the user mask
  function automatic logic level_passes(input logic [PRIO_W-1:0] prio,
                                        input logic [PRIO_W-1:0] cur_mask,
                                        input logic              user,
                                        input logic [PRIO_W-1:0] user_mask);
    return (prio > cur_mask) && (!user || (prio > user_mask));
  endfunction

  // level to CPU mask value; NMI saturates at the top mask value
  function automatic logic [PRIO_W-1:0] level_to_mask(input logic [LVL_W-1:0] lvl);
    return (lvl > LVL_W'({PRIO_W{1'b1}})) ? {PRIO_W{1'b1}} : lvl[PRIO_W-1:0];
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs import intc_pkg::*; #(
  parameter int N_SRC = 8,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  input  logic                    nmi_lvl,
  output logic [DW-1:0]           rdata,
  output logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    nmi_gate_en,
  output logic [PRIO_W-1:0]       umask
);
  localparam logic [AW-1:0] CTRL_ADDR  = AW'(N_SRC);
  localparam logic [AW-1:0] UMASK_ADDR = AW'(N_SRC + 1);

  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DW-1:PRIO_W];

  for (genvar g = 0; g < N_SRC; g++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          prio_q[g] <= '0;
      else if (we && addr == AW'(g))       prio_q[g] <= wdata[PRIO_W-1:0];
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_gate_en <= 1'b0;
      umask       <= '0;
    end else if (we) begin
      if (addr == CTRL_ADDR)  nmi_gate_en <= wdata[0];
      if (addr == UMASK_ADDR) umask       <= wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_SRC; i++)
      if (addr == AW'(i)) rdata = DW'(prio_q[i]);
    if (addr == CTRL_ADDR)  rdata = {{(DW-2){1'b0}}, nmi_lvl, nmi_gate_en};
    if (addr == UMASK_ADDR) rdata = DW'(umask);
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb import intc_pkg::*; #(
  parameter int N_SRC = 8,
  parameter int SW    = 4
) (
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic                    nmi_ok,
  input  logic [PRIO_W-1:0]       cur_mask,
  input  logic                    user,
  input  logic [PRIO_W-1:0]       user_mask,
  output logic                    win,
  output logic [LVL_W-1:0]        win_lvl,
  output logic [SW-1:0]           win_src
);
  logic [PRIO_W-1:0] p;

  always_comb begin
    win_lvl = '0;
    win_src = '0;
    p       = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < N_SRC; i++) begin
      p = prio_flat[i*PRIO_W +: PRIO_W];
      if (req[i] && level_passes(p, cur_mask, user, user_mask) &&
          (LVL_W'(p) > win_lvl)) begin
        win_lvl = LVL_W'(p);
        win_src = SW'(i);
      end
    end
    if (nmi_ok) begin
      win_lvl = NMI_LEVEL;
      win_src = SW'(N_SRC);
    end
  end

  assign win = (win_lvl != '0);
endmodule

// File: rtl/prio_intc.sv
module prio_intc import intc_pkg::*; #(
  parameter  int N_EXT = 4,
  parameter  int N_MOD = 4,
  parameter  int DW    = 8,
  localparam int N_SRC = N_EXT + N_MOD,
  localparam int SW    = $clog2(N_SRC + 1),
  localparam int AW    = $clog2(N_SRC + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic [N_MOD-1:0]  mod_req,
  input  logic              nmi_pin,
  input  logic              nmi_ack,
  input  logic [PRIO_W-1:0] cpu_imask,
  input  logic              cpu_bl,
  input  logic              cpu_user,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o,
  output logic [SW-1:0]     irq_src_o,
  output logic [PRIO_W-1:0] new_imask_o
);
  logic [N_SRC-1:0]        req_s;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic                    nmi_s, nmi_prev, nmi_pend, nmi_rise, nmi_ok;
  logic                    nmi_gate_en;
  logic [PRIO_W-1:0]       umask;
  logic                    win;
  logic [LVL_W-1:0]        win_lvl;
  logic [SW-1:0]           win_src;

  intc_sync #(.W(N_SRC)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d({mod_req, ext_req}), .q(req_s)
  );

  intc_sync #(.W(1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_n), .d(nmi_pin), .q(nmi_s)
  );

  assign nmi_rise = nmi_s & ~nmi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_s;
      if (nmi_rise)     nmi_pend <= 1'b1;
      else if (nmi_ack) nmi_pend <= 1'b0;
    end
  end

  assign nmi_ok = nmi_pend & ~(nmi_gate_en & cpu_bl);

  intc_regs #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .nmi_lvl(nmi_s), .rdata(reg_rdata), .prio_flat(prio_flat),
    .nmi_gate_en(nmi_gate_en), .umask(umask)
  );

  intc_arb #(.N_SRC(N_SRC), .SW(SW)) u_arb (
    .req(req_s), .prio_flat(prio_flat), .nmi_ok(nmi_ok), .cur_mask(cpu_imask),
    .user(cpu_user), .user_mask(umask), .win(win), .win_lvl(win_lvl),
    .win_src(win_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      irq_level_o <= '0;
      irq_src_o   <= '0;
      new_imask_o <= '0;
    end else begin
      irq_o       <= win;
      irq_level_o <= win_lvl;
      irq_src_o   <= win_src;
      new_imask_o <= level_to_mask(win_lvl);
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk import intc_pkg::*; #(
  parameter int N_SRC = 8,
  parameter int SW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PRIO_W-1:0] cpu_imask,
  input logic              cpu_bl,
  input logic              cpu_user,
  input logic              irq_o,
  input logic [LVL_W-1:0]  irq_level_o,
  input logic [SW-1:0]     irq_src_o,
  input logic [PRIO_W-1:0] new_imask_o,
  input logic              nmi_rise,
  input logic              nmi_pend,
  input logic              nmi_ok,
  input logic              nmi_gate_en,
  input logic [PRIO_W-1:0] umask
);
  localparam logic [SW-1:0] NMI_CODE = SW'(N_SRC);

  assert_imask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_src_o != NMI_CODE) |-> (irq_level_o > LVL_W'($past(cpu_imask))));

  assert_nmi_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nmi_ok) |-> (irq_o && irq_level_o == NMI_LEVEL && irq_src_o == NMI_CODE));

  assert_nmi_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> nmi_pend);

  assert_nmi_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_src_o == NMI_CODE) |-> !($past(nmi_gate_en) && $past(cpu_bl)));

  assert_new_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (new_imask_o == level_to_mask(irq_level_o)));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_level_o == '0 && irq_src_o == '0 && new_imask_o == '0));

  assert_user_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_src_o != NMI_CODE && $past(cpu_user)) |->
      (irq_level_o > LVL_W'($past(umask))));
endmodule

bind prio_intc prio_intc_chk #(.N_SRC(N_SRC), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_imask(cpu_imask), .cpu_bl(cpu_bl),
  .cpu_user(cpu_user), .irq_o(irq_o), .irq_level_o(irq_level_o),
  .irq_src_o(irq_src_o), .new_imask_o(new_imask_o), .nmi_rise(nmi_rise),
  .nmi_pend(nmi_pend), .nmi_ok(nmi_ok), .nmi_gate_en(nmi_gate_en),
  .umask(umask)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_req = '0;
  logic [3:0] mod_req = '0;
  logic       nmi_pin = 1'b0, nmi_ack = 1'b0;
  logic [3:0] cpu_imask = '0;
  logic       cpu_bl = 1'b0, cpu_user = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o;
  logic [4:0] irq_level_o;
  logic [3:0] irq_src_o;
  logic [3:0] new_imask_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .mod_req(mod_req),
    .nmi_pin(nmi_pin), .nmi_ack(nmi_ack), .cpu_imask(cpu_imask),
    .cpu_bl(cpu_bl), .cpu_user(cpu_user), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .irq_level_o(irq_level_o), .irq_src_o(irq_src_o),
    .new_imask_o(new_imask_o)
  );

  // expected output word: irq[13] level[12:8] code[7:4] mask[3:0]
  function automatic int expo(input int lvl, input int src);
    int m;
    if (lvl == 0) return 0;
    m = (lvl > 15) ? 15 : lvl;
    return (1 << 13) | (lvl << 8) | (src << 4) | m;
  endfunction

  function automatic int obs();
    return int'({irq_o, irq_level_o, irq_src_o, new_imask_o});
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_addr  = 4'(a);
    reg_wdata = 8'(d);
    reg_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    reg_addr = 4'(a);
    #1;
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic nmi_pulse();
    nmi_pin = 1'b1;
    step(1);
    nmi_pin = 1'b0;
  endtask

  task automatic do_ack();
    nmi_ack = 1'b1;
    step(1);
    nmi_ack = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R11: reset state
    check("R11 outputs", obs(), 0);
    for (int a = 0; a < 10; a++) rd_chk("R11 regs", a, 0);

    // R2/R1: single source, every priority against every CPU mask
    for (int s = 0; s < 8; s++) begin
      {mod_req, ext_req} = 8'(1 << s);
      for (int p = 0; p < 16; p++) begin
        wr(s, p);
        rd_chk("R1 readback", s, p);
        for (int m = 0; m < 16; m++) begin
          cpu_imask = 4'(m);
          step(4);
          check("R2 mask compare", obs(), (p > m) ? expo(p, s) : 0);
        end
      end
      wr(s, 0);
    end

    // R3: ties go to the lower code, higher priority otherwise wins
    {mod_req, ext_req} = 8'hFF;
    cpu_imask = 4'd0;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        if (a != b) begin
          wr(a, 7); wr(b, 7);
          step(4);
          check("R3 tie", obs(), expo(7, (a < b) ? a : b));
          wr(b, 4); wr(a, 9);
          step(4);
          check("R3 higher", obs(), expo(9, a));
          wr(a, 0); wr(b, 0);
        end

    // R8: user mask sweep on module source code 6
    {mod_req, ext_req} = 8'h40;
    cpu_user = 1'b1;
    for (int p = 0; p < 16; p++) begin
      wr(6, p);
      for (int um = 0; um < 16; um++) begin
        wr(9, um);
        step(2);
        check("R8 user mask", obs(), (p > um) ? expo(p, 6) : 0);
      end
    end
    wr(9, 15); wr(6, 5);
    cpu_user = 1'b0;
    step(2);
    check("R8 ignored outside user mode", obs(), expo(5, 6));
    wr(6, 0); wr(9, 0);

    // NMI behaviour over a background of level-15 maskable requests
    for (int i = 0; i < 8; i++) wr(i, 15);
    {mod_req, ext_req} = 8'hFF;
    cpu_imask = 4'd14;
    step(4);
    check("R3 all-15 background", obs(), expo(15, 0));
    nmi_pin = 1'b1;
    step(2);
    rd_chk("R9 pin level high", 8, 2);
    step(1);
    check("R10 NMI not yet", obs(), expo(15, 0));
    step(1);
    check("R4 NMI wins at 4th edge", obs(), expo(16, 8));
    do_ack();
    check("R5 NMI held through ack edge", obs(), expo(16, 8));
    step(1);
    check("R5 ack clears NMI", obs(), expo(15, 0));
    step(6);
    check("R5 held pin no retrigger", obs(), expo(15, 0));
    nmi_pin = 1'b0;
    step(3);
    rd_chk("R9 pin level low", 8, 0);

    // R6: block-bit gating
    wr(8, 1);
    cpu_bl = 1'b1;
    nmi_pulse();
    step(6);
    check("R6 gated NMI", obs(), expo(15, 0));
    rd_chk("R1 control readback", 8, 1);
    cpu_bl = 1'b0;
    step(1);
    check("R6 pending NMI released", obs(), expo(16, 8));
    do_ack();
    step(1);
    check("R5 ack after release", obs(), expo(15, 0));
    wr(8, 0);
    cpu_bl = 1'b1;
    nmi_pulse();
    step(5);
    check("R6 ungated ignores block bit", obs(), expo(16, 8));
    do_ack();
    step(1);
    cpu_bl = 1'b0;

    // R4: NMI with the CPU mask at its top value
    cpu_imask = 4'd15;
    step(2);
    check("R2 top mask blocks all", obs(), 0);
    nmi_pulse();
    step(5);
    check("R4 NMI above top mask", obs(), expo(16, 8));
    do_ack();
    step(1);
    check("R7 idle after ack", obs(), 0);

    // R10: request and mask latency
    for (int i = 0; i < 8; i++) wr(i, 0);
    {mod_req, ext_req} = 8'h00;
    cpu_imask = 4'd0;
    wr(0, 3);
    step(3);
    check("R10 idle", obs(), 0);
    ext_req = 4'b0001;
    step(2);
    check("R10 request before 3rd edge", obs(), 0);
    step(1);
    check("R10 request at 3rd edge", obs(), expo(3, 0));
    cpu_imask = 4'd3;
    step(1);
    check("R10 mask change at next edge", obs(), 0);

    report();
  end
endmodule